// File: doc/BRIEF.md
# Inter-Core One-Way Mailbox

This block carries messages in one direction between the application processor and the security processor. The sending side fills a small array of payload words and then sets a doorbell bit. The doorbell raises an interrupt line towards the receiving side. The receiving side services a message in a fixed order: it takes the lock, reads and checks the words, clears the doorbell, and releases the lock. While the lock is held, the sender cannot touch the payload. The sender also cannot touch it while the doorbell is pending.

A system uses two instances, one for each direction. The parameter `SEC_RX` sets the direction and, with it, the privilege rules. When `SEC_RX = 1`, the application processor sends and the security processor receives. The receiver may then lock the buffer and mask the interrupt. When `SEC_RX = 0`, the security processor sends. In that direction the application processor has no lock and no mask, and the security processor may read its own outgoing words back.

Each side has a plain register port. A request is a single-cycle strobe with a write enable, an address and data. Read data appears one clock after the request. An access that the rules forbid has no effect, reads back as zero, and sets a sticky error flag. Only the security processor can see that flag and clear it.

Top module: `icmb_mailbox`

## Requirements
- R1: Reset clears every payload word and clears the lock, doorbell, mask and error bits; the interrupt output is low.
- R2: A sender write to a word address (address bit 3 = 0, word index in bits 2:0) is accepted only when both the lock and the doorbell are clear. The receiver can then read the word back.
- R3: A sender payload write is refused while the lock is set or the doorbell is pending. The word keeps its value and the error flag is set.
- R4: Writing 1 in bit 0 at address 9 from the sender sets the doorbell, provided the lock is clear. The interrupt output equals the doorbell gated by the mask and is visible one cycle after the write.
- R5: Writing 0 in bit 0 at address 9 from the receiver clears the doorbell, and the interrupt drops.
- R6: With `SEC_RX = 1`, the security processor writes bit 0 at address 8 (lock) and at address 10 (mask). While the mask is set, the interrupt stays low even though the doorbell remains set.
- R7: With `SEC_RX = 0`, no side can set the lock or the mask. Such a write leaves the bit at 0 and sets the error flag, and the interrupt cannot be masked.
- R8: With `SEC_RX = 0`, the security processor can read back its outgoing words. A payload write from the application processor is refused and flagged.
- R9: The error flag reads at address 11 for the security processor only. Writing 0 there clears it. Any access to it from the application processor is illegal and reads back zero.
- R10: Read data appears on the cycle after the request. On a cycle with no read, or with a refused read, the read data is zero.
- R11: When both sides act on the doorbell in the same cycle, the security processor's operation wins. When an illegal access and an error-clear happen in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Application processor access strobe |
| cpu_we | input | 1 | Application processor write enable |
| cpu_addr | input | AW (4) | Application processor register address |
| cpu_wdata | input | WORD_W (64) | Application processor write data |
| cpu_rdata | output | WORD_W (64) | Application processor read data, one cycle late |
| sec_req | input | 1 | Security processor access strobe |
| sec_we | input | 1 | Security processor write enable |
| sec_addr | input | AW (4) | Security processor register address |
| sec_wdata | input | WORD_W (64) | Security processor write data |
| sec_rdata | output | WORD_W (64) | Security processor read data, one cycle late |
| irq | output | 1 | Interrupt request towards the receiver |

## Verification
The bench builds two instances with the default word width and depth (64 bits, 8 words). One has `SEC_RX = 1` and one has `SEC_RX = 0`, so both privilege variants are exercised side by side.

The first instance covers the lock, the mask and the refusal of sender writes under lock. The second covers the read-back of outgoing words and the rejection of lock and mask attempts by the application processor. Same-cycle doorbell conflicts are driven in both instances, so the two opposite outcomes of the security-side priority rule are both observed.

// File: rtl/icmb_pkg.sv
package icmb_pkg;

   // Decoded permission of a single access from one side
   typedef struct packed {
      logic pay_we;
      logic lock_we;
      logic bell_set;
      logic bell_clr;
      logic mask_we;
      logic err_clr;
      logic illegal;
      logic rd_ok;
   } grant_t;

   // Offsets inside the control page (upper half of the address space)
   localparam logic [1:0] CTL_LOCK = 2'd0;
   localparam logic [1:0] CTL_BELL = 2'd1;
   localparam logic [1:0] CTL_MASK = 2'd2;
   localparam logic [1:0] CTL_ERR  = 2'd3;

endpackage

// File: rtl/icmb_access_rules.sv
module icmb_access_rules
   import icmb_pkg::*;
#(
   parameter bit IS_SEC = 1'b0,
   parameter bit SEC_RX = 1'b1,
   parameter int IDX_W  = 3,
   localparam int AW    = IDX_W + 1
) (
   input  logic          req,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic          wbit,
   input  logic          lock_q,
   input  logic          bell_q,
   output grant_t        g
);
   localparam bit SENDER  = (IS_SEC != SEC_RX);
   localparam bit MAY_CTL = IS_SEC && SEC_RX;

   logic reserved;
   assign reserved = (addr[IDX_W-1:0] >> 2) != '0;

   always_comb begin
      g = '0;
      if (req) begin
         if (!addr[AW-1]) begin
            if (we) begin
               if (SENDER && !lock_q && !bell_q) g.pay_we  = 1'b1;
               else                              g.illegal = 1'b1;
            end else if (!SENDER || IS_SEC) begin
               g.rd_ok = 1'b1;
            end else begin
               g.illegal = 1'b1;
            end
         end else if (reserved) begin
            g.illegal = 1'b1;
         end else begin
            unique case (addr[1:0])
               CTL_LOCK: begin
                  if (!we)          g.rd_ok   = 1'b1;
                  else if (MAY_CTL) g.lock_we = 1'b1;
                  else              g.illegal = 1'b1;
               end
               CTL_BELL: begin
                  if (!we)                          g.rd_ok    = 1'b1;
                  else if (SENDER && wbit && !lock_q) g.bell_set = 1'b1;
                  else if (!SENDER && !wbit)        g.bell_clr = 1'b1;
                  else                              g.illegal  = 1'b1;
               end
               CTL_MASK: begin
                  if (!we)          g.rd_ok   = 1'b1;
                  else if (MAY_CTL) g.mask_we = 1'b1;
                  else              g.illegal = 1'b1;
               end
               default: begin
                  if (!IS_SEC)    g.illegal = 1'b1;
                  else if (!we)   g.rd_ok   = 1'b1;
                  else if (!wbit) g.err_clr = 1'b1;
                  else            g.illegal = 1'b1;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/icmb_payload.sv
module icmb_payload #(
   parameter int WORD_W = 64,
   parameter int DEPTH  = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cpu_we,
   input  logic [IDX_W-1:0]              cpu_idx,
   input  logic [WORD_W-1:0]             cpu_wdata,
   input  logic                          sec_we,
   input  logic [IDX_W-1:0]              sec_idx,
   input  logic [WORD_W-1:0]             sec_wdata,
   output logic [DEPTH-1:0][WORD_W-1:0]  words
);

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n)
            words[i] <= '0;
         else if (sec_we && sec_idx == IDX_W'(i))
            words[i] <= sec_wdata;
         else if (cpu_we && cpu_idx == IDX_W'(i))
            words[i] <= cpu_wdata;
      end
   end

endmodule

// File: rtl/icmb_ctrl_regs.sv
module icmb_ctrl_regs (
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_wbit,
   input  logic sec_wbit,
   input  logic cpu_lock_we,
   input  logic sec_lock_we,
   input  logic cpu_bell_set,
   input  logic cpu_bell_clr,
   input  logic sec_bell_set,
   input  logic sec_bell_clr,
   input  logic cpu_mask_we,
   input  logic sec_mask_we,
   input  logic err_clr,
   input  logic err_set,
   output logic lock_q,
   output logic bell_q,
   output logic mask_q,
   output logic err_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
         bell_q <= 1'b0;
         mask_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         // security side takes priority over the application side
         if (sec_lock_we)      lock_q <= sec_wbit;
         else if (cpu_lock_we) lock_q <= cpu_wbit;

         if (sec_bell_set)      bell_q <= 1'b1;
         else if (sec_bell_clr) bell_q <= 1'b0;
         else if (cpu_bell_set) bell_q <= 1'b1;
         else if (cpu_bell_clr) bell_q <= 1'b0;

         if (sec_mask_we)      mask_q <= sec_wbit;
         else if (cpu_mask_we) mask_q <= cpu_wbit;

         if (err_set)      err_q <= 1'b1;
         else if (err_clr) err_q <= 1'b0;
      end
   end

endmodule

// File: rtl/icmb_mailbox.sv
module icmb_mailbox
   import icmb_pkg::*;
#(
   parameter int  WORD_W = 64,
   parameter int  DEPTH  = 8,
   parameter bit  SEC_RX = 1'b1,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int AW     = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [AW-1:0]     cpu_addr,
   input  logic [WORD_W-1:0] cpu_wdata,
   output logic [WORD_W-1:0] cpu_rdata,
   input  logic              sec_req,
   input  logic              sec_we,
   input  logic [AW-1:0]     sec_addr,
   input  logic [WORD_W-1:0] sec_wdata,
   output logic [WORD_W-1:0] sec_rdata,
   output logic              irq
);

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("icmb_mailbox: DEPTH must be a power of two and at least 4");
   end
   if (WORD_W < 1) begin : g_bad_width
      $error("icmb_mailbox: WORD_W must be positive");
   end

   grant_t gc, gs;
   logic   lock_q, bell_q, mask_q, err_q;
   logic [DEPTH-1:0][WORD_W-1:0] words;
   logic [WORD_W-1:0] cpu_val, sec_val;

   icmb_access_rules #(.IS_SEC(1'b0), .SEC_RX(SEC_RX), .IDX_W(IDX_W)) u_rule_cpu (
      .req(cpu_req), .we(cpu_we), .addr(cpu_addr), .wbit(cpu_wdata[0]),
      .lock_q(lock_q), .bell_q(bell_q), .g(gc));

   icmb_access_rules #(.IS_SEC(1'b1), .SEC_RX(SEC_RX), .IDX_W(IDX_W)) u_rule_sec (
      .req(sec_req), .we(sec_we), .addr(sec_addr), .wbit(sec_wdata[0]),
      .lock_q(lock_q), .bell_q(bell_q), .g(gs));

   icmb_payload #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_payload (
      .clk(clk), .rst_n(rst_n),
      .cpu_we(gc.pay_we), .cpu_idx(cpu_addr[IDX_W-1:0]), .cpu_wdata(cpu_wdata),
      .sec_we(gs.pay_we), .sec_idx(sec_addr[IDX_W-1:0]), .sec_wdata(sec_wdata),
      .words(words));

   icmb_ctrl_regs u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cpu_wbit(cpu_wdata[0]), .sec_wbit(sec_wdata[0]),
      .cpu_lock_we(gc.lock_we), .sec_lock_we(gs.lock_we),
      .cpu_bell_set(gc.bell_set), .cpu_bell_clr(gc.bell_clr),
      .sec_bell_set(gs.bell_set), .sec_bell_clr(gs.bell_clr),
      .cpu_mask_we(gc.mask_we), .sec_mask_we(gs.mask_we),
      .err_clr(gc.err_clr | gs.err_clr), .err_set(gc.illegal | gs.illegal),
      .lock_q(lock_q), .bell_q(bell_q), .mask_q(mask_q), .err_q(err_q));

   function automatic logic [WORD_W-1:0] rd_mux(
      input logic [AW-1:0]                  a,
      input logic [DEPTH-1:0][WORD_W-1:0]   w,
      input logic [3:0]                     flags);
      if (!a[AW-1]) return w[a[IDX_W-1:0]];
      return WORD_W'(flags[a[1:0]]);
   endfunction

   always_comb begin
      cpu_val = rd_mux(cpu_addr, words, {err_q, mask_q, bell_q, lock_q});
      sec_val = rd_mux(sec_addr, words, {err_q, mask_q, bell_q, lock_q});
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpu_rdata <= '0;
         sec_rdata <= '0;
      end else begin
         cpu_rdata <= gc.rd_ok ? cpu_val : '0;
         sec_rdata <= gs.rd_ok ? sec_val : '0;
      end
   end

   // receiver-maskable interrupt only when the security core receives
   if (SEC_RX) begin : g_maskable
      assign irq = bell_q & ~mask_q;
   end else begin : g_unmaskable
      assign irq = bell_q;
   end

endmodule

// File: rtl/icmb_mailbox_chk.sv
module icmb_mailbox_chk #(
   parameter int WORD_W = 64,
   parameter bit SEC_RX = 1'b1,
   parameter int AW     = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic [AW-1:0]     cpu_addr,
   input logic              cpu_wbit,
   input logic [WORD_W-1:0] cpu_rdata,
   input logic              sec_req,
   input logic              sec_we,
   input logic [AW-1:0]     sec_addr,
   input logic              sec_wbit,
   input logic [WORD_W-1:0] sec_rdata,
   input logic              irq,
   input logic              lock_q,
   input logic              bell_q,
   input logic              mask_q,
   input logic              err_q
);
   localparam bit SND_SEC = !SEC_RX;
   localparam logic [AW-1:0] A_BELL = AW'((1 << (AW - 1)) | 1);
   localparam logic [AW-1:0] A_ERR  = AW'((1 << (AW - 1)) | 3);

   logic          s_req, s_we, s_wbit, r_req, r_we, r_wbit;
   logic [AW-1:0] s_addr, r_addr;
   assign s_req  = SND_SEC ? sec_req  : cpu_req;
   assign s_we   = SND_SEC ? sec_we   : cpu_we;
   assign s_addr = SND_SEC ? sec_addr : cpu_addr;
   assign s_wbit = SND_SEC ? sec_wbit : cpu_wbit;
   assign r_req  = SND_SEC ? cpu_req  : sec_req;
   assign r_we   = SND_SEC ? cpu_we   : sec_we;
   assign r_addr = SND_SEC ? cpu_addr : sec_addr;
   assign r_wbit = SND_SEC ? cpu_wbit : sec_wbit;

   logic snd_pay_wr, snd_ring, rcv_clr, sec_err_clr;
   assign snd_pay_wr  = s_req && s_we && !s_addr[AW-1];
   assign snd_ring    = s_req && s_we && s_addr == A_BELL && s_wbit && !lock_q;
   assign rcv_clr     = r_req && r_we && r_addr == A_BELL && !r_wbit;
   assign sec_err_clr = sec_req && sec_we && sec_addr == A_ERR && !sec_wbit;

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!irq && !lock_q && !bell_q && !mask_q && !err_q));

   a_r3_refused_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_pay_wr && (lock_q || bell_q)) |=> err_q);

   a_r4_ring_raises: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_ring && !(rcv_clr && !SND_SEC)) |=> bell_q);

   a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (rcv_clr && !(snd_ring && SND_SEC)) |=> (!bell_q && !irq));

   a_r6_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q |-> !irq);

   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !sec_err_clr) |=> err_q);

   a_r10_cpu_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_req |=> cpu_rdata == '0);

   a_r10_sec_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !sec_req |=> sec_rdata == '0);

   if (!SEC_RX) begin : g_s2c
      a_r7_never_locked: assert property (@(posedge clk) disable iff (!rst_n)
         !lock_q && !mask_q);
   end

endmodule

bind icmb_mailbox icmb_mailbox_chk #(.WORD_W(WORD_W), .SEC_RX(SEC_RX), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wbit(cpu_wdata[0]),
   .cpu_rdata(cpu_rdata),
   .sec_req(sec_req), .sec_we(sec_we), .sec_addr(sec_addr), .sec_wbit(sec_wdata[0]),
   .sec_rdata(sec_rdata),
   .irq(irq), .lock_q(lock_q), .bell_q(bell_q), .mask_q(mask_q), .err_q(err_q));

// File: tb/icmb_mailbox_test.sv
module icmb_mailbox_test;
   localparam int CLK_PERIOD = 10;
   localparam int W = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic         cpu_req [2];
   logic         cpu_we  [2];
   logic [3:0]   cpu_addr[2];
   logic [W-1:0] cpu_wd  [2];
   logic [W-1:0] cpu_rd  [2];
   logic         sec_req [2];
   logic         sec_we  [2];
   logic [3:0]   sec_addr[2];
   logic [W-1:0] sec_wd  [2];
   logic [W-1:0] sec_rd  [2];
   logic         irq     [2];

   // instance 0: application -> security ; instance 1: security -> application
   icmb_mailbox #(.SEC_RX(1'b1)) uut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req[0]), .cpu_we(cpu_we[0]), .cpu_addr(cpu_addr[0]),
      .cpu_wdata(cpu_wd[0]), .cpu_rdata(cpu_rd[0]),
      .sec_req(sec_req[0]), .sec_we(sec_we[0]), .sec_addr(sec_addr[0]),
      .sec_wdata(sec_wd[0]), .sec_rdata(sec_rd[0]), .irq(irq[0]));

   icmb_mailbox #(.SEC_RX(1'b0)) uut_s2c (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req[1]), .cpu_we(cpu_we[1]), .cpu_addr(cpu_addr[1]),
      .cpu_wdata(cpu_wd[1]), .cpu_rdata(cpu_rd[1]),
      .sec_req(sec_req[1]), .sec_we(sec_we[1]), .sec_addr(sec_addr[1]),
      .sec_wdata(sec_wd[1]), .sec_rdata(sec_rd[1]), .irq(irq[1]));

   int checks = 0;
   int errors = 0;
   bit run = 1'b0;

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [W-1:0] m_pay [2][8];
   bit m_lock[2], m_bell[2], m_mask[2], m_err[2];
   logic [W-1:0] m_crd[2], m_srd[2];

   task automatic model_reset();
      for (int k = 0; k < 2; k++) begin
         for (int i = 0; i < 8; i++) m_pay[k][i] = '0;
         m_lock[k] = 0; m_bell[k] = 0; m_mask[k] = 0; m_err[k] = 0;
         m_crd[k] = '0; m_srd[k] = '0;
      end
   endtask

   task automatic judge(input int k, input bit is_sec, input bit req, input bit we,
                        input logic [3:0] a, input bit wb,
                        output bit ill, output bit pw, output bit lw, output bit bs,
                        output bit bc, output bit mw, output bit ec, output logic [W-1:0] rv);
      bit sec_rx = (k == 0);
      bit sender = (is_sec != sec_rx);
      bit rok = 0;
      ill = 0; pw = 0; lw = 0; bs = 0; bc = 0; mw = 0; ec = 0; rv = '0;
      if (req) begin
         if (a < 8) begin
            if (we) begin
               if (sender && !m_lock[k] && !m_bell[k]) pw = 1; else ill = 1;
            end else if (!sender || is_sec) begin
               rok = 1; rv = m_pay[k][a[2:0]];
            end else ill = 1;
         end else if (a == 8) begin
            if (!we) begin rok = 1; rv = W'(m_lock[k]); end
            else if (is_sec && sec_rx) lw = 1; else ill = 1;
         end else if (a == 9) begin
            if (!we) begin rok = 1; rv = W'(m_bell[k]); end
            else if (sender && wb && !m_lock[k]) bs = 1;
            else if (!sender && !wb) bc = 1;
            else ill = 1;
         end else if (a == 10) begin
            if (!we) begin rok = 1; rv = W'(m_mask[k]); end
            else if (is_sec && sec_rx) mw = 1; else ill = 1;
         end else if (a == 11) begin
            if (!is_sec) ill = 1;
            else if (!we) begin rok = 1; rv = W'(m_err[k]); end
            else if (!wb) ec = 1; else ill = 1;
         end else ill = 1;
      end
      if (!rok) rv = '0;
   endtask

   task automatic model_step(input int k);
      bit ic, pc, lc, bsc, bcc, mc, ecc;
      bit is_, ps, ls, bss, bcs, ms, ecs;
      logic [W-1:0] rc, rs;
      judge(k, 0, cpu_req[k], cpu_we[k], cpu_addr[k], cpu_wd[k][0], ic, pc, lc, bsc, bcc, mc, ecc, rc);
      judge(k, 1, sec_req[k], sec_we[k], sec_addr[k], sec_wd[k][0], is_, ps, ls, bss, bcs, ms, ecs, rs);
      m_crd[k] = rc;
      m_srd[k] = rs;
      if (pc) m_pay[k][cpu_addr[k][2:0]] = cpu_wd[k];
      if (ps) m_pay[k][sec_addr[k][2:0]] = sec_wd[k];
      if (lc) m_lock[k] = cpu_wd[k][0];
      if (ls) m_lock[k] = sec_wd[k][0];
      if (bsc) m_bell[k] = 1;
      if (bcc) m_bell[k] = 0;
      if (bss) m_bell[k] = 1;
      if (bcs) m_bell[k] = 0;
      if (mc) m_mask[k] = cpu_wd[k][0];
      if (ms) m_mask[k] = sec_wd[k][0];
      if (ecc || ecs) m_err[k] = 0;
      if (ic || is_) m_err[k] = 1;
   endtask

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else for (int k = 0; k < 2; k++) model_step(k);
   end

   // every-cycle comparison against the model (R10 timing, R4 irq)
   always @(negedge clk) begin
      if (run) begin
         for (int k = 0; k < 2; k++) begin
            chk($sformatf("R10 model cpu_rdata inst%0d", k), cpu_rd[k], m_crd[k]);
            chk($sformatf("R10 model sec_rdata inst%0d", k), sec_rd[k], m_srd[k]);
            chk($sformatf("R4 model irq inst%0d", k), W'(irq[k]),
                W'(m_bell[k] && !((k == 0) && m_mask[k])));
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic idle_all();
      for (int k = 0; k < 2; k++) begin
         cpu_req[k] = 0; cpu_we[k] = 0; cpu_addr[k] = '0; cpu_wd[k] = '0;
         sec_req[k] = 0; sec_we[k] = 0; sec_addr[k] = '0; sec_wd[k] = '0;
      end
   endtask

   task automatic op(input int k,
                     input bit cr, input bit cw, input logic [3:0] ca, input logic [W-1:0] cd,
                     input bit sr, input bit sw, input logic [3:0] sa, input logic [W-1:0] sd);
      cpu_req[k] = cr; cpu_we[k] = cw; cpu_addr[k] = ca; cpu_wd[k] = cd;
      sec_req[k] = sr; sec_we[k] = sw; sec_addr[k] = sa; sec_wd[k] = sd;
      @(negedge clk);
      idle_all();
   endtask

   task automatic cwr(input int k, input logic [3:0] a, input logic [W-1:0] d);
      op(k, 1, 1, a, d, 0, 0, 4'd0, '0);
   endtask
   task automatic crd(input int k, input logic [3:0] a);
      op(k, 1, 0, a, '0, 0, 0, 4'd0, '0);
   endtask
   task automatic swr(input int k, input logic [3:0] a, input logic [W-1:0] d);
      op(k, 0, 0, 4'd0, '0, 1, 1, a, d);
   endtask
   task automatic srd(input int k, input logic [3:0] a);
      op(k, 0, 0, 4'd0, '0, 1, 0, a, '0);
   endtask

   localparam logic [W-1:0] PA = 64'hA5A5_0000_1234_5678;
   localparam logic [W-1:0] PB = 64'h0123_4567_89AB_CDEF;
   localparam logic [W-1:0] PC = 64'hDEAD_BEEF_CAFE_F00D;

   initial begin
      idle_all();
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      run = 1'b1;

      // R1: reset state
      chk("R1 irq after reset", W'(irq[0]), '0);
      srd(0, 4'd8);  chk("R1 lock after reset", sec_rd[0], '0);
      srd(0, 4'd9);  chk("R1 doorbell after reset", sec_rd[0], '0);
      srd(0, 4'd10); chk("R1 mask after reset", sec_rd[0], '0);
      srd(0, 4'd11); chk("R1 error after reset", sec_rd[0], '0);
      srd(0, 4'd3);  chk("R1 payload after reset", sec_rd[0], '0);

      // R2: sender fills the array, receiver reads it
      cwr(0, 4'd0, PA);
      cwr(0, 4'd7, PB);
      srd(0, 4'd7);  chk("R2 word 7 written", sec_rd[0], PB);
      srd(0, 4'd0);  chk("R2 word 0 written", sec_rd[0], PA);
      srd(0, 4'd11); chk("R2 no error on legal writes", sec_rd[0], '0);

      // R9: application read of its own outgoing words is refused; error handling
      crd(0, 4'd0);  chk("R9 refused read gives zero", cpu_rd[0], '0);
      srd(0, 4'd11); chk("R9 error set after refused read", sec_rd[0], 64'd1);
      swr(0, 4'd11, '0);
      srd(0, 4'd11); chk("R9 error cleared by security write", sec_rd[0], '0);

      // R4: doorbell raises interrupt
      cwr(0, 4'd9, 64'd1);
      chk("R4 irq after doorbell", W'(irq[0]), 64'd1);

      // R3: payload frozen while doorbell pending
      cwr(0, 4'd0, PC);
      srd(0, 4'd0);  chk("R3 word kept while doorbell pending", sec_rd[0], PA);
      srd(0, 4'd11); chk("R3 error after refused write", sec_rd[0], 64'd1);
      swr(0, 4'd11, '0);

      // R6: mask and lock by the security receiver
      swr(0, 4'd10, 64'd1);
      chk("R6 irq masked", W'(irq[0]), '0);
      srd(0, 4'd9);  chk("R6 doorbell still set under mask", sec_rd[0], 64'd1);
      swr(0, 4'd10, '0);
      chk("R6 irq back after unmask", W'(irq[0]), 64'd1);
      swr(0, 4'd8, 64'd1);
      srd(0, 4'd8);  chk("R6 lock taken", sec_rd[0], 64'd1);
      cwr(0, 4'd1, PC);
      srd(0, 4'd1);  chk("R3 word kept while locked", sec_rd[0], '0);

      // R5: receiver clears doorbell then unlocks
      swr(0, 4'd9, '0);
      chk("R5 irq drops after clear", W'(irq[0]), '0);
      swr(0, 4'd8, '0);
      srd(0, 4'd8);  chk("R6 lock released", sec_rd[0], '0);

      // R9: application access to error register
      crd(0, 4'd11); chk("R9 application reads error as zero", cpu_rd[0], '0);

      // R11: same-cycle doorbell conflict, security (receiver) wins
      swr(0, 4'd11, '0);
      op(0, 1, 1, 4'd9, 64'd1, 1, 1, 4'd9, 64'd0);
      chk("R11 security clear wins", W'(irq[0]), '0);
      // R11: illegal access beats error clear
      op(0, 1, 0, 4'd11, '0, 1, 1, 4'd11, 64'd0);
      srd(0, 4'd11); chk("R11 illegal beats clear", sec_rd[0], 64'd1);

      // R10: idle cycle gives zero read data
      @(negedge clk);
      chk("R10 idle read data zero", sec_rd[0], '0);

      // ---- instance 1: security sends ----
      swr(1, 4'd2, PC);
      srd(1, 4'd2);  chk("R8 security reads back outgoing word", sec_rd[1], PC);
      crd(1, 4'd2);  chk("R2 application receiver reads word", cpu_rd[1], PC);
      cwr(1, 4'd2, PA);
      crd(1, 4'd2);  chk("R8 application write refused", cpu_rd[1], PC);
      srd(1, 4'd11); chk("R8 error after application write", sec_rd[1], 64'd1);
      swr(1, 4'd11, '0);

      cwr(1, 4'd8, 64'd1);
      crd(1, 4'd8);  chk("R7 application cannot lock", cpu_rd[1], '0);
      srd(1, 4'd11); chk("R7 lock attempt flagged", sec_rd[1], 64'd1);
      swr(1, 4'd11, '0);
      swr(1, 4'd8, 64'd1);
      crd(1, 4'd8);  chk("R7 security sender cannot lock", cpu_rd[1], '0);
      swr(1, 4'd11, '0);

      swr(1, 4'd9, 64'd1);
      chk("R4 irq towards application", W'(irq[1]), 64'd1);
      cwr(1, 4'd10, 64'd1);
      chk("R7 interrupt not maskable", W'(irq[1]), 64'd1);
      crd(1, 4'd10); chk("R7 mask stays clear", cpu_rd[1], '0);
      swr(1, 4'd11, '0);
      swr(1, 4'd3, PB);
      srd(1, 4'd3);  chk("R3 sender write refused while pending", sec_rd[1], '0);
      swr(1, 4'd11, '0);

      cwr(1, 4'd9, 64'd0);
      chk("R5 application clears doorbell", W'(irq[1]), '0);
      op(1, 1, 1, 4'd9, 64'd0, 1, 1, 4'd9, 64'd1);
      chk("R11 security set wins", W'(irq[1]), 64'd1);

      @(negedge clk);
      run = 1'b0;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule